// File: doc/BRIEF.md
# Buck Converter Start-Up and Fault Sequencer

This block is the digital supervisor of a synchronous step-down controller. It runs on the system clock and is advanced by a one-clock pulse that marks each switching period. Its inputs are comparator decisions that other logic has already digitised: supply ready, enable above threshold, feedback in undervoltage, overcurrent, compensation node pulled to shutdown, and feedback above the upper or below the lower power-good level.

On enable, it produces a reference code that climbs from zero to full scale over a fixed number of switching periods. It opens the gate drives while the ramp runs and while the loop regulates. If feedback collapses during regulation, it turns the drives off, waits out a timed pause and ramps again. An overcurrent event shuts the drives off until the supply or the enable is withdrawn. A power-good flag with hysteresis is reported only while the converter regulates.

The ramp and the restart pause share one cycle counter of `CNT_W` bits, so each lasts 2^`CNT_W` switching periods (2048 with the default of 11). The width of the reference code is `REF_W`.

Top module: `bsq_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it is released with `por_ok` low, `ss_ref` is 0, `drv_en` is 0 and `pgood` is 0.
- R2: Drives and ramp need both `por_ok` and `en_ok` high. When `en_ok` is low, `drv_en` and `ss_ref` are 0 in the same cycle without waiting for a clock edge. A later start ramps again from code 0.
- R3: During the ramp, the cycle counter advances by one only on clock edges where `cyc_tick` is high. `ss_ref` equals the top `REF_W` bits of the counter, or the counter shifted left when `REF_W` > `CNT_W`, so the code never falls.
- R4: On the 2^`CNT_W`-th tick of the ramp, the block enters regulation. `ss_ref` then holds all ones and `drv_en` stays 1.
- R5: When `fb_uv` is high during regulation, `drv_en` and `ss_ref` are 0 from the next edge. After a further 2^`CNT_W` ticks, the ramp restarts from code 0 with `drv_en` 1.
- R6: `fb_uv` has no effect during the ramp: the code keeps rising and `drv_en` stays 1.
- R7: When `ocp_trip` is high during the ramp or during regulation, `drv_en` is 0 from the next edge and stays 0 through any number of ticks and any `fb_uv` activity. Only a low on `en_ok` or on `por_ok` clears this state.
- R8: During regulation, `pgood` rises one edge after `fb_above_pg` is seen high. It falls one edge after `fb_below_pg` is seen high. It holds its value while neither input is high.
- R9: `pgood` is 0 during the ramp, the restart pause and the overcurrent shut-off, whatever the power-good inputs show.
- R10: `comp_low` forces `drv_en` to 0 in the same cycle and clears `pgood`. It does not reset the sequence: when `comp_low` is released, regulation resumes with the code unchanged.
- R11: A low on `por_ok` takes priority over every other input. It clears the overcurrent shut-off, the counter and `pgood`, and `pgood` falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-clock pulse per switching period |
| por_ok | input | 1 | Supply ready flag |
| en_ok | input | 1 | Enable comparator above threshold |
| fb_uv | input | 1 | Feedback below the restart level |
| ocp_trip | input | 1 | Overcurrent comparator tripped |
| comp_low | input | 1 | Compensation node pulled to shutdown |
| fb_above_pg | input | 1 | Feedback above the upper power-good level |
| fb_below_pg | input | 1 | Feedback below the lower power-good level |
| ss_ref | output | REF_W | Soft-start reference code |
| drv_en | output | 1 | Gate-drive enable |
| pgood | output | 1 | Power-good flag |

## Verification
The bench uses a small configuration (4-bit counter, 3-bit code) so that every step of each ramp and each pause can be checked against a code computed by shifting the tick count. Ticks are spaced with idle clocks between them, which separates counting on the tick from counting on the clock. The ramp is run three ways: from a clean enable, after an undervoltage pause, and after a mid-ramp enable drop. These show whether the counter really clears on each entry. Overcurrent is raised both during the ramp and during regulation, then held against long undervoltage activity and released by enable and by supply loss in turn. The power-good inputs are driven through the band between the two thresholds to tell hysteresis from a plain comparator.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
   typedef enum logic [2:0] {
      ST_OFF       = 3'd0,
      ST_SOFTSTART = 3'd1,
      ST_RUN       = 3'd2,
      ST_HICCUP    = 3'd3,
      ST_LATCHED   = 3'd4
   } bsq_state_e;
endpackage

// File: rtl/bsq_cycle_cnt.sv
module bsq_cycle_cnt #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt,
   output logic             at_max
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("bsq_cycle_cnt: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (inc)    cnt <= cnt + 1'b1;
   end

   assign at_max = (cnt == CNT_MAX);

   // R3: counter moves only to zero or up by one
   p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> (cnt == '0 || cnt == CNT_W'($past(cnt) + 1'b1)));

   // R3: without clear or increment the counter holds
   p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clr) && !$past(inc)) |-> $stable(cnt));
endmodule

// File: rtl/bsq_ref_map.sv
module bsq_ref_map #(
   parameter int CNT_W = 11,
   parameter int REF_W = 8
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic             ramp,
   input  logic             full,
   output logic [REF_W-1:0] ref_code
);
   logic [REF_W-1:0] scaled;

   generate
      if (REF_W < 1) begin : g_bad_ref
         $error("bsq_ref_map: REF_W must be at least 1");
      end
      if (REF_W <= CNT_W) begin : g_take_msbs
         assign scaled = cnt[CNT_W-1 -: REF_W];
      end else begin : g_pad_lsbs
         assign scaled = {cnt, {(REF_W-CNT_W){1'b0}}};
      end
   endgenerate

   always_comb begin
      if (full)      ref_code = {REF_W{1'b1}};
      else if (ramp) ref_code = scaled;
      else           ref_code = '0;
   end
endmodule

// File: rtl/bsq_pg_hyst.sv
module bsq_pg_hyst (
   input  logic clk,
   input  logic rst_n,
   input  logic allow,
   input  logic above_hi,
   input  logic below_lo,
   output logic pg_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pg_q <= 1'b0;
      else if (!allow)   pg_q <= 1'b0;
      else if (above_hi) pg_q <= 1'b1;
      else if (below_lo) pg_q <= 1'b0;
   end

   // R8: a rise needs the upper level seen while allowed
   p_pg_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg_q) |-> ($past(above_hi) && $past(allow)));

   // R8: a fall needs the lower level or a withdrawn allow
   p_pg_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pg_q) |-> ($past(below_lo) || !$past(allow)));
endmodule

// File: rtl/bsq_sequencer.sv
module bsq_sequencer
   import bsq_pkg::*;
#(
   parameter int CNT_W = 11,
   parameter int REF_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_tick,
   input  logic             por_ok,
   input  logic             en_ok,
   input  logic             fb_uv,
   input  logic             ocp_trip,
   input  logic             comp_low,
   input  logic             fb_above_pg,
   input  logic             fb_below_pg,
   output logic [REF_W-1:0] ss_ref,
   output logic             drv_en,
   output logic             pgood
);
   bsq_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt;
   logic             cnt_max;
   logic             cnt_clr;
   logic             cnt_inc;
   logic             rail_ok;
   logic             pg_allow;
   logic             pg_q;

   assign rail_ok = por_ok && en_ok;

   always_comb begin
      state_d = state_q;
      if (!rail_ok) begin
         state_d = ST_OFF;
      end else begin
         unique case (state_q)
            ST_OFF:       state_d = ST_SOFTSTART;
            ST_SOFTSTART: begin
               if (ocp_trip)                state_d = ST_LATCHED;
               else if (cyc_tick && cnt_max) state_d = ST_RUN;
            end
            ST_RUN: begin
               if (ocp_trip)   state_d = ST_LATCHED;
               else if (fb_uv) state_d = ST_HICCUP;
            end
            ST_HICCUP: begin
               if (cyc_tick && cnt_max) state_d = ST_SOFTSTART;
            end
            ST_LATCHED:   state_d = ST_LATCHED;
            default:      state_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_OFF;
      else        state_q <= state_d;
   end

   assign cnt_clr = !rail_ok || (state_d != state_q);
   assign cnt_inc = cyc_tick && (state_q == ST_SOFTSTART || state_q == ST_HICCUP);

   bsq_cycle_cnt #(.CNT_W(CNT_W)) cnt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cnt_clr),
      .inc    (cnt_inc),
      .cnt    (cnt),
      .at_max (cnt_max)
   );

   bsq_ref_map #(.CNT_W(CNT_W), .REF_W(REF_W)) ref_i (
      .cnt      (cnt),
      .ramp     (rail_ok && state_q == ST_SOFTSTART),
      .full     (rail_ok && state_q == ST_RUN),
      .ref_code (ss_ref)
   );

   assign pg_allow = rail_ok && !comp_low && (state_q == ST_RUN);

   bsq_pg_hyst pg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .allow    (pg_allow),
      .above_hi (fb_above_pg),
      .below_lo (fb_below_pg),
      .pg_q     (pg_q)
   );

   assign pgood  = pg_q && pg_allow;
   assign drv_en = rail_ok && !comp_low &&
                   (state_q == ST_SOFTSTART || state_q == ST_RUN);

   // R2, R11: losing supply or enable returns to idle with a cleared counter
   p_idle_on_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rail_ok) |-> (state_q == ST_OFF && cnt == '0));

   // R3: the reference never drops while the ramp continues
   p_ref_monotonic_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SOFTSTART && $past(state_q) == ST_SOFTSTART && rail_ok && $past(rail_ok))
      |-> (ss_ref >= $past(ss_ref)));

   // R5: the restart pause is entered only from regulation on undervoltage
   p_hiccup_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HICCUP && $past(state_q) != ST_HICCUP)
      |-> ($past(state_q) == ST_RUN && $past(fb_uv)));

   // R7: the overcurrent shut-off holds while supply and enable stay up
   p_latch_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LATCHED && rail_ok) |=> (state_q == ST_LATCHED));

   // R7: the shut-off is reached only through an overcurrent trip
   p_latch_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LATCHED && $past(state_q) != ST_LATCHED) |-> $past(ocp_trip));
endmodule

// File: tb/bsq_sequencer_tb.sv
module bsq_sequencer_tb_top;
   localparam int CNT_W = 4;
   localparam int REF_W = 3;
   localparam int NSTEP = 1 << CNT_W;
   localparam int SHIFT = CNT_W - REF_W;
   localparam int FULL  = (1 << REF_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cyc_tick = 1'b0;
   logic             por_ok = 1'b0;
   logic             en_ok = 1'b0;
   logic             fb_uv = 1'b0;
   logic             ocp_trip = 1'b0;
   logic             comp_low = 1'b0;
   logic             fb_above_pg = 1'b0;
   logic             fb_below_pg = 1'b0;
   logic [REF_W-1:0] ss_ref;
   logic             drv_en;
   logic             pgood;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   bsq_sequencer #(.CNT_W(CNT_W), .REF_W(REF_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .por_ok(por_ok),
      .en_ok(en_ok), .fb_uv(fb_uv), .ocp_trip(ocp_trip), .comp_low(comp_low),
      .fb_above_pg(fb_above_pg), .fb_below_pg(fb_below_pg),
      .ss_ref(ss_ref), .drv_en(drv_en), .pgood(pgood)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic clk1();
      @(posedge clk);
      #1;
   endtask

   task automatic tick();
      cyc_tick = 1'b1;
      clk1();
      cyc_tick = 1'b0;
      clk1();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) clk1();
      chk("R1", "ref in reset", ss_ref, 0);
      chk("R1", "drv in reset", drv_en, 0);
      chk("R1", "pgood in reset", pgood, 0);
      rst_n = 1'b1;
      clk1();
      chk("R1", "drv no por", drv_en, 0);

      // R2 enable gating
      por_ok = 1'b1;
      repeat (3) clk1();
      chk("R2", "drv without enable", drv_en, 0);
      en_ok = 1'b1;
      clk1();
      chk("R2", "drv at ramp start", drv_en, 1);
      chk("R2", "ref at ramp start", ss_ref, 0);

      // R3 R4 R6 R9 ramp
      for (int k = 1; k <= NSTEP; k++) begin
         fb_uv       = (k >= 3 && k <= 8);
         fb_above_pg = (k >= 3 && k <= 8);
         fb_below_pg = !(k >= 3 && k <= 8);
         tick();
         if (k < NSTEP) begin
            chk("R3", "ramp code", ss_ref, k >> SHIFT);
            if (k >= 3 && k <= 8) begin
               chk("R6", "drv with uv in ramp", drv_en, 1);
               chk("R9", "pgood in ramp", pgood, 0);
            end
         end
      end
      chk("R4", "ref after ramp", ss_ref, FULL);
      chk("R4", "drv after ramp", drv_en, 1);

      // R8 hysteresis
      chk("R8", "pgood below band", pgood, 0);
      fb_above_pg = 1'b1; fb_below_pg = 1'b0;
      clk1();
      chk("R8", "pgood rise", pgood, 1);
      fb_above_pg = 1'b0;
      repeat (3) clk1();
      chk("R8", "pgood held in band", pgood, 1);
      fb_below_pg = 1'b1;
      clk1();
      chk("R8", "pgood fall", pgood, 0);
      fb_below_pg = 1'b0;
      repeat (3) clk1();
      chk("R8", "pgood stays low in band", pgood, 0);

      // R10 compensation shutdown
      fb_above_pg = 1'b1;
      clk1();
      chk("R8", "pgood re-rise", pgood, 1);
      comp_low = 1'b1;
      #1;
      chk("R10", "drv same cycle", drv_en, 0);
      clk1();
      chk("R10", "pgood cleared", pgood, 0);
      comp_low = 1'b0;
      #1;
      chk("R10", "drv resumes", drv_en, 1);
      chk("R10", "ref unchanged", ss_ref, FULL);
      fb_above_pg = 1'b0; fb_below_pg = 1'b1;
      clk1();

      // R5 undervoltage restart
      fb_uv = 1'b1;
      clk1();
      fb_uv = 1'b0;
      chk("R5", "drv in pause", drv_en, 0);
      chk("R5", "ref in pause", ss_ref, 0);
      for (int k = 1; k < NSTEP; k++) tick();
      chk("R5", "drv before pause ends", drv_en, 0);
      tick();
      chk("R5", "drv after pause", drv_en, 1);
      chk("R5", "ref restarts at zero", ss_ref, 0);
      for (int k = 1; k <= NSTEP; k++) tick();
      chk("R4", "ref after second ramp", ss_ref, FULL);

      // R7 overcurrent in regulation
      ocp_trip = 1'b1;
      clk1();
      ocp_trip = 1'b0;
      chk("R7", "drv after trip", drv_en, 0);
      fb_uv = 1'b1;
      for (int k = 0; k < 40; k++) tick();
      fb_uv = 1'b0;
      clk1();
      chk("R7", "drv stays off", drv_en, 0);
      chk("R7", "ref stays zero", ss_ref, 0);
      en_ok = 1'b0;
      clk1();
      en_ok = 1'b1;
      clk1();
      chk("R7", "enable clears trip", drv_en, 1);
      chk("R7", "ramp from zero", ss_ref, 0);

      // R2 mid-ramp enable drop
      for (int k = 0; k < 5; k++) tick();
      chk("R3", "mid ramp code", ss_ref, 5 >> SHIFT);
      en_ok = 1'b0;
      #1;
      chk("R2", "drv off at once", drv_en, 0);
      chk("R2", "ref off at once", ss_ref, 0);
      clk1();
      en_ok = 1'b1;
      clk1();
      tick();
      tick();
      chk("R2", "ramp restarted", ss_ref, 2 >> SHIFT);

      // R7 overcurrent in ramp, R11 supply loss
      ocp_trip = 1'b1;
      clk1();
      ocp_trip = 1'b0;
      chk("R7", "drv after ramp trip", drv_en, 0);
      por_ok = 1'b0;
      clk1();
      por_ok = 1'b1;
      clk1();
      chk("R11", "supply loss clears trip", drv_en, 1);
      chk("R11", "counter cleared", ss_ref, 0);
      for (int k = 1; k <= NSTEP; k++) tick();
      fb_above_pg = 1'b1; fb_below_pg = 1'b0;
      clk1();
      chk("R8", "pgood in regulation", pgood, 1);
      por_ok = 1'b0;
      #1;
      chk("R11", "pgood same cycle", pgood, 0);
      clk1();
      chk("R11", "drv on supply loss", drv_en, 0);
      por_ok = 1'b1;
      clk1();
      clk1();
      chk("R9", "pgood after restart", pgood, 0);

      summary();
      $finish;
   end
endmodule